// File: doc/BRIEF.md
# Receive-Level Hardware Handshake Controller

This block runs the hardware handshake of one serial channel. On the receive side it watches the fill level of the channel's receive FIFO. When the level climbs past a trigger point plus a selectable hysteresis band, it deasserts the outgoing "ready to accept" pin, which is active low. It asserts the pin again only once the level has drained to the trigger point minus the same band. It also raises a level-type interrupt request while the FIFO holds at least the trigger number of characters.

On the transmit side it synchronises the incoming "peer ready" pin, which is active low, and produces a permit that the transmitter samples before it starts each new character. A character already being shifted out is finished by the transmitter whatever the permit does. No new character starts while the permit is low. One select input picks which pin pair carries the handshake: either request-to-send/clear-to-send, or terminal-ready/set-ready.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready interface and no back-pressure rules. The receive and transmit halves have separate enables.

Top module: `modem_flow_ctrl`

## Requirements
- R1: During and right after reset, `trig_irq` is 0, `tx_permit` is 0 while `auto_cts_en` is 1, the selected outgoing handshake pin is 0 (asserted) and the unselected one is 1.
- R2: With `auto_rts_en` at 0, the selected outgoing pin is 0 and `trig_irq` is 0 one cycle later, whatever the FIFO level.
- R3: With `auto_rts_en` at 1, the selected outgoing pin goes to 1 one clock after `fifo_level` >= upper. Here upper = min(trigger + band, DEPTH).
- R4: While the pin is 1, it returns to 0 one clock after `fifo_level` <= lower and `fifo_level` < upper. Here lower = max(trigger - band, 0).
- R5: While `fifo_level` lies strictly between lower and upper, the outgoing pin keeps its previous value.
- R6: The band in characters for `hyst_sel` codes 0 to 15 is, in code order: 0, 4, 6, 8, 8, 16, 24, 32, 12, 20, 28, 36, 40, 44, 48, 52.
- R7: `trig_irq` is 1 one clock after `fifo_level` >= `trig_level` while `auto_rts_en` is 1, and is 0 otherwise.
- R8: With `pair_sel` = 1, the flow state drives `dtr_n` and the permit follows `dsr_n`, while `rts_n` stays 1. With `pair_sel` = 0, the flow state drives `rts_n` and the permit follows `cts_n`, while `dtr_n` stays 1.
- R9: With `auto_cts_en` at 1, `tx_permit` equals the inverse of the selected peer pin as it was two clock edges earlier (two-flop synchroniser). With `auto_cts_en` at 0, `tx_permit` is 1.
- R10: When the band reaches past the FIFO limits, upper saturates at DEPTH (64) and lower saturates at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_level | input | 7 | Receive FIFO fill level, 0 to DEPTH |
| trig_level | input | 7 | Receive trigger level |
| hyst_sel | input | 4 | Hysteresis band code |
| auto_rts_en | input | 1 | Enable receive-level flow control |
| auto_cts_en | input | 1 | Enable transmit gating from peer pin |
| pair_sel | input | 1 | 0: RTS/CTS pair, 1: DTR/DSR pair |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Set-ready pin, active low, asynchronous |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| tx_permit | output | 1 | Transmitter may start a new character |
| trig_irq | output | 1 | Receive trigger interrupt request, level |

## Verification
The bench builds the block with the default DEPTH of 64, so levels run over the whole 0 to 64 range. It sweeps every band code with a trigger of 32, which exposes each table entry as an exact switch point on a full ramp up and down. Triggers of 60 and 4 with the widest band drive upper and lower into their saturation limits. A zero band and both pin pairs, including toggling the unselected peer pin, complete the coverage.

// File: rtl/flow_hs_pkg.sv
package flow_hs_pkg;

  typedef enum logic {
    PAIR_RTS_CTS = 1'b0,
    PAIR_DTR_DSR = 1'b1
  } hs_pair_e;

  localparam int BAND_W = 6;

  // Band width in characters for each hysteresis code (R6)
  function automatic logic [BAND_W-1:0] band_chars(input logic [3:0] code);
    logic [BAND_W-1:0] b;
    case (code)
      4'd0:  b = 6'd0;
      4'd1:  b = 6'd4;
      4'd2:  b = 6'd6;
      4'd3:  b = 6'd8;
      4'd4:  b = 6'd8;
      4'd5:  b = 6'd16;
      4'd6:  b = 6'd24;
      4'd7:  b = 6'd32;
      4'd8:  b = 6'd12;
      4'd9:  b = 6'd20;
      4'd10: b = 6'd28;
      4'd11: b = 6'd36;
      4'd12: b = 6'd40;
      4'd13: b = 6'd44;
      4'd14: b = 6'd48;
      default: b = 6'd52;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/flow_hs_thresh.sv
module flow_hs_thresh #(
  parameter int DEPTH = 64,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] trig,
  input  logic [3:0]       band_sel,
  output logic [LVL_W-1:0] upper,
  output logic [LVL_W-1:0] lower
);
  import flow_hs_pkg::*;

  localparam int SUM_W = LVL_W + 1;

  logic [SUM_W-1:0] band_ext;
  logic [SUM_W-1:0] raw_up;
  logic [SUM_W-1:0] trig_ext;

  always_comb begin
    band_ext = SUM_W'(band_chars(band_sel));
    trig_ext = {1'b0, trig};
    raw_up   = trig_ext + band_ext;
    // R10: clip the band at the FIFO limits
    if (raw_up > SUM_W'(DEPTH)) upper = LVL_W'(DEPTH);
    else                        upper = raw_up[LVL_W-1:0];
    if (trig_ext > band_ext)    lower = trig - band_ext[LVL_W-1:0];
    else                        lower = '0;
  end

endmodule

// File: rtl/flow_hs_rxgate.sv
module flow_hs_rxgate #(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] trig,
  input  logic [LVL_W-1:0] upper,
  input  logic [LVL_W-1:0] lower,
  output logic             stop,
  output logic             irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop <= 1'b0;
      irq  <= 1'b0;
    end else if (!en) begin
      stop <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= (level >= trig);
      if (stop) begin
        if ((level <= lower) && (level < upper)) stop <= 1'b0;
      end else if (level >= upper) begin
        stop <= 1'b1;
      end
    end
  end

  assert_off_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!stop && !irq));

  assert_stop_at_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && level >= upper) |=> stop);

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && level <= lower && level < upper) |=> !stop);

  assert_band_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && level > lower && level < upper) |=> $stable(stop));

  assert_irq_at_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && level >= trig) |=> irq);

endmodule

// File: rtl/flow_hs_sync.sv
module flow_hs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;  // pins idle deasserted
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/flow_hs_txgate.sv
module flow_hs_txgate (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  flow_hs_pkg::hs_pair_e pair,
  input  logic                  cts_s_n,
  input  logic                  dsr_s_n,
  output logic                  tx_permit
);
  import flow_hs_pkg::*;

  logic peer_n;

  always_comb begin
    peer_n    = (pair == PAIR_DTR_DSR) ? dsr_s_n : cts_s_n;
    tx_permit = !en || !peer_n;
  end

  assert_permit_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> tx_permit);

endmodule

// File: rtl/modem_flow_ctrl.sv
module modem_flow_ctrl #(
  parameter int DEPTH = 64,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] trig_level,
  input  logic [3:0]       hyst_sel,
  input  logic             auto_rts_en,
  input  logic             auto_cts_en,
  input  logic             pair_sel,
  input  logic             cts_n,
  input  logic             dsr_n,
  output logic             rts_n,
  output logic             dtr_n,
  output logic             tx_permit,
  output logic             trig_irq
);
  import flow_hs_pkg::*;

  hs_pair_e         pair;
  logic [LVL_W-1:0] upper;
  logic [LVL_W-1:0] lower;
  logic             stop;
  logic [1:0]       peer_s_n;

  assign pair = hs_pair_e'(pair_sel);

  flow_hs_thresh #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_thresh (
    .trig     (trig_level),
    .band_sel (hyst_sel),
    .upper    (upper),
    .lower    (lower)
  );

  flow_hs_rxgate #(.LVL_W(LVL_W)) u_rxgate (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (auto_rts_en),
    .level (fifo_level),
    .trig  (trig_level),
    .upper (upper),
    .lower (lower),
    .stop  (stop),
    .irq   (trig_irq)
  );

  flow_hs_sync #(.W(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({dsr_n, cts_n}),
    .q     (peer_s_n)
  );

  flow_hs_txgate u_txgate (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (auto_cts_en),
    .pair      (pair),
    .cts_s_n   (peer_s_n[0]),
    .dsr_s_n   (peer_s_n[1]),
    .tx_permit (tx_permit)
  );

  // Only the selected pin carries flow state; the other idles high
  always_comb begin
    rts_n = (pair == PAIR_RTS_CTS) ? stop : 1'b1;
    dtr_n = (pair == PAIR_DTR_DSR) ? stop : 1'b1;
  end

  assert_idle_pin_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_sel |-> rts_n) and (!pair_sel |-> dtr_n));

endmodule

// File: tb/modem_flow_ctrl_bench.sv
module modem_flow_ctrl_bench;
  localparam int DEPTH = 64;
  localparam int LW    = 7;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic          rst_n = 1'b0;
  logic [LW-1:0] fifo_level = '0, trig_level = '0;
  logic [3:0]    hyst_sel = '0;
  logic          auto_rts_en = 1'b0, auto_cts_en = 1'b1, pair_sel = 1'b0;
  logic          cts_n = 1'b1, dsr_n = 1'b1;
  logic          rts_n, dtr_n, tx_permit, trig_irq;

  modem_flow_ctrl u_modem_flow_ctrl (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .trig_level(trig_level),
    .hyst_sel(hyst_sel), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
    .pair_sel(pair_sel), .cts_n(cts_n), .dsr_n(dsr_n), .rts_n(rts_n),
    .dtr_n(dtr_n), .tx_permit(tx_permit), .trig_irq(trig_irq)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  // Scoreboard: expected {rts_n, dtr_n, irq, permit} and requirement tag
  logic [3:0] exp_q[$];
  string      tag_q[$];

  // Bench-side reference state
  logic m_stop = 0, m_irq = 0;
  logic m_c1 = 1, m_c2 = 1, m_d1 = 1, m_d2 = 1;

  function automatic int band(input int code);
    case (code)
      0: return 0;   1: return 4;   2: return 6;   3: return 8;
      4: return 8;   5: return 16;  6: return 24;  7: return 32;
      8: return 12;  9: return 20;  10: return 28; 11: return 36;
      12: return 40; 13: return 44; 14: return 48; default: return 52;
    endcase
  endfunction

  task automatic apply(input int lvl, input int trg, input int code,
                       input bit er, input bit ec, input bit dtr,
                       input bit cn, input bit dn, input string tag);
    int up, lo;
    logic peer;
    @(negedge clk);
    fifo_level = LW'(lvl); trig_level = LW'(trg); hyst_sel = 4'(code);
    auto_rts_en = er; auto_cts_en = ec; pair_sel = dtr; cts_n = cn; dsr_n = dn;
    up = trg + band(code); if (up > DEPTH) up = DEPTH;
    lo = trg - band(code); if (lo < 0) lo = 0;
    if (!er) begin
      m_stop = 0; m_irq = 0;
    end else begin
      m_irq = (lvl >= trg);
      if (m_stop) begin
        if (lvl <= lo && lvl < up) m_stop = 0;
      end else if (lvl >= up) m_stop = 1;
    end
    m_c2 = m_c1; m_c1 = cn; m_d2 = m_d1; m_d1 = dn;
    peer = dtr ? m_d2 : m_c2;
    exp_q.push_back({dtr ? 1'b1 : m_stop, dtr ? m_stop : 1'b1, m_irq, !ec || !peer});
    tag_q.push_back(tag);
  endtask

  // Monitor: compares just after each rising edge
  initial forever begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({rts_n, dtr_n, trig_irq, tx_permit} !== e) begin
        errors++;
        $display("FAIL %s: {rts_n,dtr_n,irq,permit} actual=%b expected=%b at %0t",
                 t, {rts_n, dtr_n, trig_irq, tx_permit}, e, $time);
      end
    end
  end

  task automatic ramp(input int trg, input int code, input bit dtr, input string tag);
    for (int l = 0; l <= DEPTH; l++) apply(l, trg, code, 1, 0, dtr, 1, 1, tag);
    for (int l = DEPTH; l >= 0; l--) apply(l, trg, code, 1, 0, dtr, 1, 1, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if ({rts_n, dtr_n, trig_irq, tx_permit} !== 4'b0100) begin
      errors++;
      $display("FAIL R1: reset outputs actual=%b expected=0100",
               {rts_n, dtr_n, trig_irq, tx_permit});
    end
    apply(0, 32, 1, 0, 1, 0, 1, 1, "R1");
    // R2: disabled receive side ignores a full FIFO
    apply(64, 32, 1, 0, 0, 0, 1, 1, "R2");
    apply(64, 32, 1, 0, 0, 0, 1, 1, "R2");
    // R3/R4/R5/R7: trigger 32, band 4 -> up 36, low 28
    for (int l = 30; l <= 37; l++) apply(l, 32, 1, 1, 0, 0, 1, 1, "R3");
    for (int l = 37; l >= 26; l--) apply(l, 32, 1, 1, 0, 0, 1, 1, "R4");
    apply(33, 32, 1, 1, 0, 0, 1, 1, "R7");
    apply(31, 32, 1, 1, 0, 0, 1, 1, "R7");
    apply(40, 32, 1, 1, 0, 0, 1, 1, "R5");
    apply(30, 32, 1, 1, 0, 0, 1, 1, "R5");
    apply(29, 32, 1, 1, 0, 0, 1, 1, "R5");
    apply(40, 32, 1, 0, 0, 0, 1, 1, "R2");
    // R6: every band code
    for (int c = 0; c < 16; c++) ramp(32, c, 0, "R6");
    // R10: saturation at both ends
    ramp(60, 15, 0, "R10");
    ramp(4, 15, 0, "R10");
    ramp(0, 0, 0, "R10");
    // R8: terminal-ready pair
    ramp(20, 2, 1, "R8");
    // R9: peer pin gating and synchroniser delay, both pairs
    for (int i = 0; i < 6; i++) apply(0, 32, 0, 0, 1, 0, (i >= 2) ? 1'b0 : 1'b1, 1, "R9");
    for (int i = 0; i < 4; i++) apply(0, 32, 0, 0, 1, 0, 1, 0, "R9");
    for (int i = 0; i < 4; i++) apply(0, 32, 0, 0, 0, 0, 1, 1, "R9");
    for (int i = 0; i < 4; i++) apply(0, 32, 0, 0, 1, 1, 1, 0, "R8");
    for (int i = 0; i < 4; i++) apply(0, 32, 0, 0, 1, 1, 0, 1, "R8");
    for (int i = 0; i < 4; i++) apply(0, 32, 0, 0, 1, 1, 0, 0, "R8");
    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule